// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a banked on-chip scratchpad and serves one warp-wide request at a time. A request carries, for every lane, an active bit, a word address, a write flag and write data. Each word address selects a bank from its low bits. Lanes that hit different banks are served in the same cycle. Lanes that hit the same bank at different words are spread over several passes. Lanes that touch the very same word are merged into one access, which broadcasts the word to all of them. The bank storage is a set of synchronous single-port RAMs inside the block.

A request is offered with `req_valid` and taken on a clock edge where `req_ready` is high. `req_ready` is high only while the block is idle. While a request is being served `req_ready` stays low, so a source that holds `req_valid` high is simply made to wait: nothing it drives is sampled until `req_ready` returns. When every lane has been served, `done` pulses for one cycle. From that cycle on, `rd_data` holds the per-lane results until the next request is accepted.

Top module: `sp_conflict_arbiter`

## Requirements
- R1: The bank of a lane is its word address modulo BANKS, taken from the low log2(BANKS) address bits. The row inside the bank is taken from the remaining upper bits. A request whose active lanes all fall in distinct banks is served in one pass.
- R2: The pass count N is the largest number of distinct words that the active lanes address within any single bank, with a minimum of 1. `done` is high in the clock cycle that follows the (N+1)-th rising edge after the accepting edge.
- R3: Lanes that address the same word share one pass and all receive that word. Such shared groups in different banks are served in the same pass.
- R4: A request whose lane l addresses base + s*l, with s odd, is conflict-free and takes one pass.
- R5: Inactive lanes are ignored. Their `rd_data` field reads zero, and their write flag writes nothing.
- R6: Every active lane, reader or writer, returns the value its word held before the request was accepted.
- R7: When several active lanes write the same word in one request, the word ends up holding the data of the highest-numbered of those lanes.
- R8: `req_ready` is low from the accepting edge until `done` is high. `req_valid` is ignored while `req_ready` is low. `done` lasts exactly one cycle. `rd_data` stays unchanged after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request (idle) |
| req_active | input | LANES | Per-lane active bit |
| req_write | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| req_addr | input | LANES*ADDR_W | Per-lane word address, lane l at bits [l*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*DATA_W | Per-lane write data, lane l at bits [l*DATA_W +: DATA_W] |
| rd_data | output | LANES*DATA_W | Per-lane result, lane l at bits [l*DATA_W +: DATA_W] |
| done | output | 1 | One-cycle pulse: the request is fully served |

## Verification
The bench builds the block with its defaults: 32 lanes, 32 banks, 10-bit word addresses and 32-bit data. These values bring within reach the full 32-way conflict, where every lane addresses a different word in bank 0. They also allow 32-row banks, so the whole 1024-word space is first filled through the block and every word has a known value. Small random address windows then produce mixed conflicts, broadcasts and same-word write collisions. The reference model predicts each of these in both pass count and data.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DRAIN = 2'd2
  } arb_state_e;
endpackage

// File: rtl/sp_bank_ram.sv
module sp_bank_ram #(
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first: the read returns the word as it was before this edge's write
  always_ff @(posedge clk) begin
    if (en) begin
      if (wr) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/sp_bank_pick.sv
module sp_bank_pick #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 5,
  parameter int BANK_ID = 0,
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  pending,
  input  logic [ADDR_W-1:0] addr  [LANES],
  input  logic [LANES-1:0]  wr_flag,
  input  logic [DATA_W-1:0] wdata [LANES],
  output logic [LANES-1:0]  grant,
  output logic              en,
  output logic              wr,
  output logic [ROW_W-1:0]  row,
  output logic [DATA_W-1:0] wd
);
  logic [LANES-1:0]  in_bank;
  logic [ADDR_W-1:0] lead_addr;
  logic              found;

  always_comb begin
    found     = 1'b0;
    lead_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      in_bank[l] = pending[l] && (addr[l][BANK_W-1:0] == BANK_W'(BANK_ID));
      if (!found && in_bank[l]) begin
        found     = 1'b1;
        lead_addr = addr[l];
      end
    end
    for (int l = 0; l < LANES; l++) begin
      grant[l] = in_bank[l] && (addr[l] == lead_addr);
    end
    // ascending scan: the highest granted writer is the last to assign
    wr = 1'b0;
    wd = '0;
    for (int l = 0; l < LANES; l++) begin
      if (grant[l] && wr_flag[l]) begin
        wr = 1'b1;
        wd = wdata[l];
      end
    end
    en  = found;
    row = lead_addr[ADDR_W-1:BANK_W];
  end

  // a bank with pending work always makes progress this pass
  p_bank_progress_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_bank) |-> (grant != '0));
endmodule

// File: rtl/sp_conflict_arbiter.sv
module sp_conflict_arbiter
  import sp_arb_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [LANES-1:0]         req_active,
  input  logic [LANES-1:0]         req_write,
  input  logic [LANES*ADDR_W-1:0]  req_addr,
  input  logic [LANES*DATA_W-1:0]  req_wdata,
  output logic [LANES*DATA_W-1:0]  rd_data,
  output logic                     done
);
  arb_state_e        state;
  logic [LANES-1:0]  pending, cap_mask, wr_q, served;
  logic [ADDR_W-1:0] addr_q  [LANES];
  logic [DATA_W-1:0] wdata_q [LANES];
  logic [DATA_W-1:0] res_q   [LANES];
  logic [LANES-1:0]  grant_b [BANKS];
  logic [DATA_W-1:0] bank_rd [BANKS];

  assign req_ready = (state == ST_IDLE);

  genvar b, g;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      logic              b_en, b_wr;
      logic [ROW_W-1:0]  b_row;
      logic [DATA_W-1:0] b_wd;

      sp_bank_pick #(
        .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BANK_W(BANK_W), .BANK_ID(b)
      ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .pending((state == ST_BUSY) ? pending : '0),
        .addr(addr_q), .wr_flag(wr_q), .wdata(wdata_q),
        .grant(grant_b[b]), .en(b_en), .wr(b_wr), .row(b_row), .wd(b_wd)
      );

      sp_bank_ram #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .en(b_en), .wr(b_wr), .row(b_row),
        .wdata(b_wd), .rdata(bank_rd[b])
      );
    end
    for (g = 0; g < LANES; g++) begin : g_lane
      assign rd_data[g*DATA_W +: DATA_W] = res_q[g];
    end
  endgenerate

  always_comb begin
    served = '0;
    for (int i = 0; i < BANKS; i++) served = served | grant_b[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pending  <= '0;
      cap_mask <= '0;
      wr_q     <= '0;
      done     <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        addr_q[l]  <= '0;
        wdata_q[l] <= '0;
        res_q[l]   <= '0;
      end
    end else begin
      done     <= 1'b0;
      cap_mask <= '0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          pending <= req_active;
          wr_q    <= req_write;
          for (int l = 0; l < LANES; l++) begin
            addr_q[l]  <= req_addr[l*ADDR_W +: ADDR_W];
            wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
            res_q[l]   <= '0;
          end
          state <= ST_BUSY;
        end
        ST_BUSY: begin
          pending  <= pending & ~served;
          cap_mask <= served;
          if ((pending & ~served) == '0) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      // RAM data of the previous pass lands in the lanes it served
      for (int l = 0; l < LANES; l++) begin
        if (cap_mask[l]) res_q[l] <= bank_rd[addr_q[l][BANK_W-1:0]];
      end
    end
  end

  p_accept_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_when_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  p_pending_shrinks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && pending != '0) |=>
      ($countones(pending) < $past($countones(pending))));
  p_served_was_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> ((served & ~pending) == '0));
  p_busy_holds_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |=> $stable(wr_q));
endmodule

// File: tb/sp_conflict_arbiter_tb.sv
module sp_conflict_arbiter_tb;
  localparam int LANES = 32, BANKS = 32, ADDR_W = 10, DATA_W = 32;
  localparam int WORDS = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [LANES-1:0] req_active = '0, req_write = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES*DATA_W-1:0] req_wdata = '0;
  logic req_ready, done;
  logic [LANES*DATA_W-1:0] rd_data;

  int checks = 0, failures = 0, cycles = 0;
  logic [DATA_W-1:0] model [WORDS];
  bit               t_act [LANES];
  bit               t_we  [LANES];
  logic [ADDR_W-1:0] t_addr [LANES];
  logic [DATA_W-1:0] t_wd   [LANES];

  always #10 clk = ~clk;

  sp_conflict_arbiter #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_req();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 0; t_we[l] = 0; t_addr[l] = '0; t_wd[l] = '0;
    end
  endtask

  task automatic run_req(input string tag, input bit junk);
    int n;
    logic [DATA_W-1:0] exp_rd [LANES];
    logic [LANES*DATA_W-1:0] held;
    n = 1;
    for (int bk = 0; bk < BANKS; bk++) begin
      int cnt;
      cnt = 0;
      for (int l = 0; l < LANES; l++) begin
        bit seen;
        seen = 0;
        if (t_act[l] && (int'(t_addr[l]) % BANKS) == bk) begin
          for (int m = 0; m < l; m++)
            if (t_act[m] && t_addr[m] == t_addr[l]) seen = 1;
          if (!seen) cnt++;
        end
      end
      if (cnt > n) n = cnt;
    end
    for (int l = 0; l < LANES; l++) exp_rd[l] = t_act[l] ? model[t_addr[l]] : '0;
    for (int l = 0; l < LANES; l++) if (t_act[l] && t_we[l]) model[t_addr[l]] = t_wd[l];

    @(negedge clk);
    chk(req_ready === 1'b1, "R8", "ready before offer", {31'd0, req_ready}, 1);
    req_valid = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      req_active[l] = t_act[l];
      req_write[l]  = t_we[l];
      req_addr[l*ADDR_W +: ADDR_W]  = t_addr[l];
      req_wdata[l*DATA_W +: DATA_W] = t_wd[l];
    end
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      chk(req_ready === 1'b0, tag, "ready low while busy", {31'd0, req_ready}, 0);
      chk(done === 1'b0, tag, "done early", {31'd0, done}, 0);
      if (k == 0) begin
        req_valid = junk;
        req_active = '1; req_write = '1;
        for (int l = 0; l < LANES; l++) begin
          req_addr[l*ADDR_W +: ADDR_W]  = ADDR_W'(l);
          req_wdata[l*DATA_W +: DATA_W] = 32'hDEAD0000 + l;
        end
      end
      if (k == n) req_valid = 1'b0;
    end
    @(negedge clk);
    chk(done === 1'b1, tag, "done at N+1", {31'd0, done}, 1);
    chk(req_ready === 1'b1, "R8", "ready with done", {31'd0, req_ready}, 1);
    for (int l = 0; l < LANES; l++)
      chk(rd_data[l*DATA_W +: DATA_W] === exp_rd[l], tag, $sformatf("lane %0d data", l),
          rd_data[l*DATA_W +: DATA_W], exp_rd[l]);
    held = rd_data;
    @(negedge clk);
    chk(done === 1'b0, "R8", "done one cycle", {31'd0, done}, 0);
    chk(rd_data === held, "R8", "data held", rd_data[DATA_W-1:0], held[DATA_W-1:0]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R8", "reset ready", {31'd0, req_ready}, 1);
    chk(done === 1'b0, "R8", "reset done", {31'd0, done}, 0);
    chk(rd_data === '0, "R5", "reset data", rd_data[DATA_W-1:0], 0);
    rst_n = 1'b1;

    // fill every word, stride 1, one pass each (R1)
    for (int r = 0; r < WORDS / LANES; r++) begin
      clear_req();
      for (int l = 0; l < LANES; l++) begin
        t_act[l] = 1; t_we[l] = 1;
        t_addr[l] = ADDR_W'(r * LANES + l);
        t_wd[l] = 32'h5A000000 ^ (r * 32'h10001) ^ (l * 32'h01010101);
      end
      run_req("R1", 0);
    end
    // stride 1 read, R1
    clear_req();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1; t_addr[l] = ADDR_W'(64 + l); end
    run_req("R1", 0);
    // stride 2: two passes, R2
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(2 * l);
    run_req("R2", 0);
    // stride 32: all lanes in bank 0, 32 passes, R2
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(32 * l + 32);
    run_req("R2", 0);
    // odd strides, R4
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(3 * l + 5);
    run_req("R4", 0);
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(7 * l + 300);
    run_req("R4", 0);
    // broadcast of one word, and two groups in different banks, R3
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(7);
    run_req("R3", 0);
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'((l % 2) ? 20 : 12);
    run_req("R3", 0);
    // inactive lanes: zero data, their writes dropped, R5
    clear_req();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = (l % 2) == 0; t_we[l] = (l % 2) == 1;
      t_addr[l] = ADDR_W'(400 + l); t_wd[l] = 32'hBAD00000 + l;
    end
    run_req("R5", 0);
    clear_req();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1; t_addr[l] = ADDR_W'(400 + l); end
    run_req("R5", 0);
    // mixed read/write on one word: readers see the old value, R6
    clear_req();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 1; t_we[l] = l >= 16; t_addr[l] = ADDR_W'(200); t_wd[l] = 32'hC0DE0000 + l;
    end
    run_req("R6", 0);
    // write collision, highest lane wins, then read back, R7
    clear_req();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 1; t_we[l] = 1; t_addr[l] = ADDR_W'(100 + 32 * (l % 3)); t_wd[l] = 32'h77000000 + l;
    end
    run_req("R7", 0);
    clear_req();
    for (int l = 0; l < 3; l++) begin t_act[l] = 1; t_addr[l] = ADDR_W'(100 + 32 * l); end
    run_req("R7", 0);
    // valid held with junk while busy must be ignored, R8
    clear_req();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1; t_addr[l] = ADDR_W'(16 * l); end
    run_req("R8", 1);
    clear_req();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1; t_addr[l] = ADDR_W'(l); end
    run_req("R8", 0);
    // random small windows: conflicts, broadcasts, collisions
    for (int r = 0; r < 40; r++) begin
      for (int l = 0; l < LANES; l++) begin
        t_act[l]  = $urandom_range(0, 3) != 0;
        t_we[l]   = $urandom_range(0, 3) == 0;
        t_addr[l] = ADDR_W'($urandom_range(0, 127));
        t_wd[l]   = $urandom;
      end
      run_req("R2", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule